// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Detector

This block watches a bank of already-synchronized GPIO input pins and turns their activity into interrupt requests. Every line is configured on its own. It can act on a level, high or low. It can act on a single edge, rising or falling. It can also act on every transition. The block records what it sees in a raw status vector and gates that vector with a per-line enable. It then drives one combined interrupt request.

Software reaches the block through a simple register bus with a select, a write strobe, a byte address and a data word one bit per line. Edge-detected events stay latched until software writes a 1 to the line's bit in the clear register. Level-detected events are not stored: they follow the pin and drop once the pin leaves its active level. Bit i of every register belongs to line i.

Top module: `pinirq_unit`

## Requirements
- R1: After reset, the sense, both-edges, event and enable registers hold 0, raw status is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: Register offsets are sense 0x404, both-edges 0x408, event 0x40C and enable 0x410, all read/write. Raw status is at 0x414 and masked status is at 0x418, both read-only. The clear register is at 0x41C and reads as 0. A read with `bus_sel`=1 and `bus_wr`=0 returns the addressed register on `bus_rdata` after the next clock edge. Bit i is line i.
- R3: With sense bit = 1, the line is level-sensitive. Event bit 1 selects active-high and event bit 0 selects active-low. Raw status equals "pin is at the active level" as registered one clock after the pin is sampled.
- R4: Level-sensitive status is not latched. It falls as soon as the pin leaves the active level, and writes to the clear register do not affect it.
- R5: With sense = 0 and both-edges = 1, both a rising and a falling transition set the raw status bit, whatever the event bit holds.
- R6: With sense = 0 and both-edges = 0, event bit 1 detects only rising transitions and event bit 0 detects only falling transitions. The opposite transition leaves status unchanged.
- R7: Edge status stays set until a 1 is written to that line's bit at 0x41C. Writing 0 bits leaves status unchanged.
- R8: When an edge on a line is detected in the same clock cycle as a clear write for that line, the status bit remains set.
- R9: Masked status reads as raw status AND enable.
- R10: `irq_out` is a register that equals the OR of all masked status bits, updated on the same edge as the status.
- R11: Writes to the raw and masked status addresses change nothing.
- R12: An edge is a difference between the sampled pin and its value sampled one clock earlier. The earlier-sample register resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NLINES | Synchronized pin values |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | NLINES | Write data, bit per line |
| bus_rdata | output | NLINES | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NLINES = 8 and ADDR_W = 12, so that the full address map decodes and every sensing mode can run at once on a different line. Lines 0–3 are placed in level mode with mixed polarities while lines 4–7 cover rising, falling and both-edge sensing, with and without a meaningful event bit. This lets a single status read show several modes answering to the same pin change. That layout also brings within reach a level line ignoring a clear that hits a neighbouring latched edge line, and an edge arriving on the very cycle of its own clear.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam logic [11:0] OFS_SENSE = 12'h404;
  localparam logic [11:0] OFS_BOTH  = 12'h408;
  localparam logic [11:0] OFS_EVENT = 12'h40C;
  localparam logic [11:0] OFS_EN    = 12'h410;
  localparam logic [11:0] OFS_RAW   = 12'h414;
  localparam logic [11:0] OFS_MASK  = 12'h418;
  localparam logic [11:0] OFS_CLR   = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_BOTH, SEL_EVENT, SEL_EN, SEL_RAW, SEL_MASK, SEL_CLR
  } reg_sel_e;

endpackage

// File: rtl/pinirq_line.sv
module pinirq_line (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic event_i,
  input  logic clr_i,
  output logic raw_q,
  output logic raw_d
);

  logic prev_q;
  logic rise, fall, hit, lvl;

  always_comb begin
    rise  = pin_i & ~prev_q;
    fall  = ~pin_i & prev_q;
    hit   = both_i ? (rise | fall) : (event_i ? rise : fall);
    lvl   = (pin_i == event_i);
    // a fresh edge overrides a clear in the same cycle
    raw_d = sense_i ? lvl : ((raw_q & ~clr_i) | hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      raw_q  <= raw_d;
    end
  end

  p_level_track_r3: assert property (@(posedge clk) disable iff (rst)
    sense_i |=> raw_q == $past(pin_i == event_i));

  p_both_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (!sense_i && both_i && (pin_i != prev_q)) |=> raw_q);

  p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!sense_i && raw_q && !clr_i) |=> raw_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!sense_i && clr_i && (pin_i == prev_q)) |=> !raw_q);

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic [NLINES-1:0] raw_q,
  output logic [NLINES-1:0] sense_q,
  output logic [NLINES-1:0] both_q,
  output logic [NLINES-1:0] event_q,
  output logic [NLINES-1:0] en_q,
  output logic [NLINES-1:0] en_d,
  output logic [NLINES-1:0] clr_vec,
  output logic [NLINES-1:0] bus_rdata
);

  reg_sel_e sel;
  logic     wr;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_SENSE): sel = SEL_SENSE;
      ADDR_W'(OFS_BOTH):  sel = SEL_BOTH;
      ADDR_W'(OFS_EVENT): sel = SEL_EVENT;
      ADDR_W'(OFS_EN):    sel = SEL_EN;
      ADDR_W'(OFS_RAW):   sel = SEL_RAW;
      ADDR_W'(OFS_MASK):  sel = SEL_MASK;
      ADDR_W'(OFS_CLR):   sel = SEL_CLR;
      default:            sel = SEL_NONE;
    endcase
    wr      = bus_sel & bus_wr;
    en_d    = (wr && sel == SEL_EN) ? bus_wdata : en_q;
    clr_vec = (wr && sel == SEL_CLR) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      en_q    <= '0;
    end else begin
      en_q <= en_d;
      if (wr) begin
        case (sel)
          SEL_SENSE: sense_q <= bus_wdata;
          SEL_BOTH:  both_q  <= bus_wdata;
          SEL_EVENT: event_q <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (sel)
        SEL_SENSE: bus_rdata <= sense_q;
        SEL_BOTH:  bus_rdata <= both_q;
        SEL_EVENT: bus_rdata <= event_q;
        SEL_EN:    bus_rdata <= en_q;
        SEL_RAW:   bus_rdata <= raw_q;
        SEL_MASK:  bus_rdata <= raw_q & en_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(sense_q) && $stable(both_q) && $stable(event_q) && $stable(en_q)));

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> $stable(bus_rdata));

endmodule

// File: rtl/pinirq_unit.sv
module pinirq_unit #(
  parameter int NLINES = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq_out
);

  logic [NLINES-1:0] sense_q, both_q, event_q, en_q, en_d, clr_vec;
  logic [NLINES-1:0] raw_q, raw_d;
  logic              irq_q;

  pinirq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .raw_q    (raw_q),
    .sense_q  (sense_q),
    .both_q   (both_q),
    .event_q  (event_q),
    .en_q     (en_q),
    .en_d     (en_d),
    .clr_vec  (clr_vec),
    .bus_rdata(bus_rdata)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    pinirq_line u_line (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_in[g]),
      .sense_i(sense_q[g]),
      .both_i (both_q[g]),
      .event_i(event_q[g]),
      .clr_i  (clr_vec[g]),
      .raw_q  (raw_q[g]),
      .raw_d  (raw_d[g])
    );
  end

  // registered request, aligned with the status flops
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_d & en_d);
  end

  assign irq_out = irq_q;

  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(raw_q & en_q));

endmodule

// File: tb/tb_pinirq_unit.sv
`timescale 1ns/1ps
module tb_pinirq_unit;

  localparam int NLINES = 8;
  localparam int ADDR_W = 12;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2, OP_I = 2'd3;
  localparam int NV = 61;

  // {op, addr, data/expected, requirement number}
  localparam logic [25:0] TBL [NV] = '{
    {OP_R, 12'h404, 8'h00, 4'd1},   // R1 sense reset
    {OP_R, 12'h414, 8'h00, 4'd1},   // R1 raw reset
    {OP_W, 12'h404, 8'hA5, 4'd2},
    {OP_R, 12'h404, 8'hA5, 4'd2},   // R2
    {OP_W, 12'h408, 8'h3C, 4'd2},
    {OP_R, 12'h408, 8'h3C, 4'd2},   // R2
    {OP_W, 12'h40C, 8'h0F, 4'd2},
    {OP_R, 12'h40C, 8'h0F, 4'd2},   // R2
    {OP_W, 12'h410, 8'hFF, 4'd2},
    {OP_R, 12'h410, 8'hFF, 4'd2},   // R2
    {OP_R, 12'h41C, 8'h00, 4'd2},   // R2 clear reads 0
    {OP_W, 12'h404, 8'h0F, 4'd3},
    {OP_W, 12'h408, 8'hC0, 4'd5},
    {OP_W, 12'h40C, 8'h55, 4'd6},
    {OP_W, 12'h41C, 8'hFF, 4'd7},
    {OP_R, 12'h414, 8'h0A, 4'd3},   // R3 active-low lines set at pin 0
    {OP_W, 12'h410, 8'h00, 4'd9},
    {OP_R, 12'h418, 8'h00, 4'd9},   // R9
    {OP_I, 12'h000, 8'h00, 4'd10},  // R10
    {OP_W, 12'h410, 8'h02, 4'd9},
    {OP_R, 12'h418, 8'h02, 4'd9},   // R9
    {OP_I, 12'h000, 8'h01, 4'd10},  // R10
    {OP_P, 12'h000, 8'h01, 4'd3},
    {OP_R, 12'h414, 8'h0B, 4'd3},   // R3 active-high line 0
    {OP_P, 12'h000, 8'h0F, 4'd4},
    {OP_R, 12'h414, 8'h05, 4'd4},   // R4 low-level lines drop
    {OP_W, 12'h41C, 8'h05, 4'd4},
    {OP_R, 12'h414, 8'h05, 4'd4},   // R4 clear ignored
    {OP_W, 12'h410, 8'h00, 4'd9},
    {OP_P, 12'h000, 8'h1F, 4'd6},
    {OP_R, 12'h414, 8'h15, 4'd6},   // R6 rising on line 4
    {OP_P, 12'h000, 8'h0F, 4'd7},
    {OP_R, 12'h414, 8'h15, 4'd7},   // R7 latched
    {OP_P, 12'h000, 8'h2F, 4'd6},
    {OP_R, 12'h414, 8'h15, 4'd6},   // R6 rising ignored on falling line
    {OP_P, 12'h000, 8'h0F, 4'd6},
    {OP_R, 12'h414, 8'h35, 4'd6},   // R6 falling on line 5
    {OP_W, 12'h41C, 8'h00, 4'd7},
    {OP_R, 12'h414, 8'h35, 4'd7},   // R7 zero write
    {OP_W, 12'h41C, 8'h10, 4'd7},
    {OP_R, 12'h414, 8'h25, 4'd7},   // R7 clear line 4
    {OP_P, 12'h000, 8'h4F, 4'd5},
    {OP_P, 12'h000, 8'h0F, 4'd5},
    {OP_R, 12'h414, 8'h65, 4'd5},   // R5
    {OP_W, 12'h41C, 8'h40, 4'd5},
    {OP_P, 12'h000, 8'h8F, 4'd5},
    {OP_R, 12'h414, 8'hA5, 4'd5},   // R5 event bit 0 ignored
    {OP_W, 12'h41C, 8'hA0, 4'd5},
    {OP_P, 12'h000, 8'h0F, 4'd5},
    {OP_R, 12'h414, 8'h85, 4'd5},   // R5 falling
    {OP_W, 12'h410, 8'h81, 4'd9},
    {OP_R, 12'h418, 8'h81, 4'd9},   // R9
    {OP_I, 12'h000, 8'h01, 4'd10},  // R10
    {OP_W, 12'h410, 8'h10, 4'd9},
    {OP_R, 12'h418, 8'h00, 4'd9},   // R9
    {OP_I, 12'h000, 8'h00, 4'd10},  // R10
    {OP_W, 12'h414, 8'hFF, 4'd11},
    {OP_R, 12'h414, 8'h85, 4'd11},  // R11
    {OP_W, 12'h418, 8'hFF, 4'd11},
    {OP_R, 12'h418, 8'h00, 4'd11},  // R11
    {OP_R, 12'h41C, 8'h00, 4'd2}    // R2
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NLINES-1:0] pin_in = '0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NLINES-1:0] bus_wdata = '0;
  logic [NLINES-1:0] bus_rdata;
  logic              irq_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pinirq_unit #(.NLINES(NLINES), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [7:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_pins(input logic [7:0] v);
    pin_in = v;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      string tag;
      v = TBL[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      case (v[25:24])
        OP_W: do_write(v[23:12], v[11:4]);
        OP_R: do_read(v[23:12], v[11:4], tag);
        OP_P: do_pins(v[11:4]);
        default: check(tag, {7'd0, irq_out}, v[11:4]);
      endcase
    end

    // R8: edge on line 4 in the very cycle its clear is written
    pin_in = 8'h1F;
    do_write(12'h41C, 8'h10);
    check("R8 irq", {7'd0, irq_out}, 8'h01);
    do_read(12'h414, 8'h95, "R8 edge beats clear");
    do_write(12'h41C, 8'h10);
    do_read(12'h414, 8'h85, "R7 clear without edge");

    // R1: reset in mid-run returns all state to zero
    rst = 1'b1; pin_in = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rst = 1'b0;
    do_read(12'h404, 8'h00, "R1 sense cleared");
    do_read(12'h410, 8'h00, "R1 enable cleared");
    do_read(12'h414, 8'h00, "R1 R12 raw cleared, no false edge");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule